// File: doc/BRIEF.md
# Clock frequency window monitor

This block watches a fast system clock and confirms that it runs within an allowed frequency band. The yardstick is a slow, trusted reference clock of 32.768 kHz, which is taken to be accurate. The reference is sampled into the system clock domain through a flop chain. Each of its rising edges ends one measurement window. A saturating counter in the system domain counts the system cycles in each window. At every rising edge of the reference the period just measured is compared with a programmed minimum and a programmed maximum.

A separate supervisor checks that reference edges keep arriving. If none arrives within a programmable number of system cycles, it raises its own error, so a dead reference cannot pass as a healthy one. All three errors are sticky until a clear or a reset. The check is suspended whenever the system clock is itself derived from the reference oscillator, because the comparison then has no meaning.

The sequencing is held in a three-state machine:
- **IDLE**: nothing is checked.
- **ARM**: waits for the first reference edge and throws away the partial window that ends there.
- **MEASURE**: every reference edge ends a window, and that window is compared.

The transitions are:
- IDLE→ARM when the block is active (enable high, bypass low).
- ARM→MEASURE on a reference edge.
- ARM→ARM on a clear.
- MEASURE→ARM on a clear.
- Any state→IDLE when the block stops being active.

Top module: `clk_freq_guard`

## Requirements
- R1: Each rising edge of `ref_clk` is detected once, after the synchroniser. The measured period N is the number of `sys_clk` cycles between two consecutive detected edges.
- R2: In MEASURE, a window with N < `lo_limit` sets `err_slow`.
- R3: In MEASURE, a window with N > `hi_limit` sets `err_fast`. The limits are inclusive: N equal to either limit sets neither error.
- R4: The first window after the block becomes active, and the first window after a clear, is not compared.
- R5: The cycle counter saturates at 2^CNT_W−1 rather than wrapping. A window longer than that reads as 2^CNT_W−1.
- R6: `err_slow`, `err_fast` and `err_noref` are sticky. Once set, each stays set while `clear` is low, even if later windows are in range.
- R7: While the block is active, if more than `timeout` `sys_clk` cycles pass without a detected reference edge, `err_noref` is set. Any shorter gap leaves it low.
- R8: A one-cycle pulse on `clear` drives all three error flags to 0 in the next cycle.
- R9: While `bypass` is high or `enable` is low, the block is in IDLE and sets no error flag.
- R10: After reset, all three error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock under test |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Trusted 32.768 kHz reference, asynchronous to `sys_clk` |
| enable | input | 1 | Turns monitoring on |
| bypass | input | 1 | High when the system clock is derived from the reference; suspends checking |
| clear | input | 1 | Clears all error flags and restarts with a discarded window |
| lo_limit | input | CNT_W | Minimum allowed period, in system cycles |
| hi_limit | input | CNT_W | Maximum allowed period, in system cycles |
| timeout | input | TO_W | Longest allowed gap between reference edges, in system cycles |
| err_slow | output | 1 | Sticky: a measured period fell below `lo_limit` |
| err_fast | output | 1 | Sticky: a measured period exceeded `hi_limit` |
| err_noref | output | 1 | Sticky: the reference edges stopped arriving |

## Verification
The bench builds the block with CNT_W = 8 and TO_W = 12. With an 8-bit counter, a 600-cycle reference period runs past saturation. A wrapping counter would instead read 88 and land inside the window, so the two behaviours give different results. A 12-bit timeout of 1000 cycles sits well above every healthy period the bench uses (up to 600) and well below the 1200-cycle gap used to stop the reference. The inclusive limit edges are tested with periods of 20 cycles against limits of 20 and 21.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARM     = 2'd1,
        ST_MEASURE = 2'd2
    } cfm_state_t;
endpackage

// File: rtl/cfm_edge_sync.sv
module cfm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            last  <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~last;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R1
endmodule

// File: rtl/cfm_sat_counter.sv
module cfm_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (restart)
            count <= W'(1);
        else if (count != TOP)
            count <= count + W'(1);
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (count == TOP) && !restart |=> (count == TOP)); // R5
endmodule

// File: rtl/cfm_ref_watchdog.sv
module cfm_ref_watchdog #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         kick,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gap <= '0;
        else if (kick)
            gap <= '0;
        else if (gap != limit)
            gap <= gap + W'(1);
    end

    assign expired = (gap == limit) && !kick;

    AST_KICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (gap == '0)); // R7
endmodule

// File: rtl/clk_freq_guard.sv
module clk_freq_guard
    import cfm_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int TO_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             sys_clk,
    input  logic             rst_n,
    input  logic             ref_clk,
    input  logic             enable,
    input  logic             bypass,
    input  logic             clear,
    input  logic [CNT_W-1:0] lo_limit,
    input  logic [CNT_W-1:0] hi_limit,
    input  logic [TO_W-1:0]  timeout,
    output logic             err_slow,
    output logic             err_fast,
    output logic             err_noref
);
    cfm_state_t       state, state_nxt;
    logic             tick;
    logic [CNT_W-1:0] period;
    logic             wd_expired;
    logic             active;

    assign active = enable & ~bypass;

    cfm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (sys_clk),
        .rst_n    (rst_n),
        .async_in (ref_clk),
        .rise     (tick)
    );

    cfm_sat_counter #(.W(CNT_W)) u_count (
        .clk     (sys_clk),
        .rst_n   (rst_n),
        .restart (tick),
        .count   (period)
    );

    cfm_ref_watchdog #(.W(TO_W)) u_wd (
        .clk     (sys_clk),
        .rst_n   (rst_n),
        .kick    (tick | clear | (state == ST_IDLE)),
        .limit   (timeout),
        .expired (wd_expired)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (active) state_nxt = ST_ARM;
            ST_ARM: begin
                if (!active)     state_nxt = ST_IDLE;
                else if (clear)  state_nxt = ST_ARM;
                else if (tick)   state_nxt = ST_MEASURE;
            end
            ST_MEASURE: begin
                if (!active)     state_nxt = ST_IDLE;
                else if (clear)  state_nxt = ST_ARM;
            end
            default:             state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            err_slow  <= 1'b0;
            err_fast  <= 1'b0;
            err_noref <= 1'b0;
        end else if (clear) begin
            err_slow  <= 1'b0;
            err_fast  <= 1'b0;
            err_noref <= 1'b0;
        end else begin
            if (state == ST_MEASURE && tick && active) begin
                if (period < lo_limit) err_slow <= 1'b1;
                if (period > hi_limit) err_fast <= 1'b1;
            end
            if (state != ST_IDLE && active && wd_expired)
                err_noref <= 1'b1;
        end
    end

    AST_CLEAR_FLAGS: assert property (@(posedge sys_clk) disable iff (!rst_n)
        clear |=> !err_slow && !err_fast && !err_noref); // R8
    AST_STICKY_FAST: assert property (@(posedge sys_clk) disable iff (!rst_n)
        err_fast && !clear |=> err_fast); // R6
    AST_STICKY_SLOW: assert property (@(posedge sys_clk) disable iff (!rst_n)
        err_slow && !clear |=> err_slow); // R6
    AST_IDLE_QUIET: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (state == ST_IDLE) && !err_fast && !err_slow && !err_noref
        |=> !err_fast && !err_slow && !err_noref); // R9
    AST_ARM_DISCARD: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (state == ST_ARM) && !err_slow && !err_fast |=> !err_slow && !err_fast); // R4
endmodule

// File: tb/clk_freq_guard_test.sv
module clk_freq_guard_test;
    localparam int CW = 8;
    localparam int TW = 12;

    logic          sys_clk = 1'b0;
    logic          rst_n   = 1'b0;
    logic          ref_clk = 1'b0;
    logic          enable  = 1'b0;
    logic          bypass  = 1'b0;
    logic          clear   = 1'b0;
    logic [CW-1:0] lo_limit = '0;
    logic [CW-1:0] hi_limit = '1;
    logic [TW-1:0] timeout  = TW'(1000);
    logic          err_slow, err_fast, err_noref;

    int  ref_half = 10;
    bit  ref_run  = 1'b0;
    int  checks   = 0;
    int  fails    = 0;
    bit  done     = 1'b0;

    clk_freq_guard #(.CNT_W(CW), .TO_W(TW)) uut (
        .sys_clk(sys_clk), .rst_n(rst_n), .ref_clk(ref_clk),
        .enable(enable), .bypass(bypass), .clear(clear),
        .lo_limit(lo_limit), .hi_limit(hi_limit), .timeout(timeout),
        .err_slow(err_slow), .err_fast(err_fast), .err_noref(err_noref)
    );

    always #2 sys_clk = ~sys_clk;

    initial begin : refgen
        int ph;
        ph = 0;
        forever begin
            @(negedge sys_clk);
            if (ref_run) begin
                if (ph >= ref_half - 1) begin
                    ref_clk = ~ref_clk;
                    ph = 0;
                end else begin
                    ph++;
                end
            end
        end
    end

    typedef struct packed {
        int          half;
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic        slow;
        logic        fast;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{10,  8'd18, 8'd22,  1'b0, 1'b0},  // R2 R3 nominal
        '{10,  8'd21, 8'd30,  1'b1, 1'b0},  // R2 too slow
        '{10,  8'd10, 8'd19,  1'b0, 1'b1},  // R3 too fast
        '{10,  8'd20, 8'd20,  1'b0, 1'b0},  // R3 inclusive edges
        '{10,  8'd21, 8'd21,  1'b1, 1'b0},  // R2 one below
        '{100, 8'd10, 8'd150, 1'b0, 1'b1},  // R3 long period
        '{300, 8'd0,  8'd254, 1'b0, 1'b1}   // R5 saturation
    };

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge sys_clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic pulse_clear();
        clear = 1'b1;
        wait_cycles(1);
        clear = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge sys_clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(1);
        check("R10 slow", err_slow, 1'b0);
        check("R10 fast", err_fast, 1'b0);
        check("R10 noref", err_noref, 1'b0);

        for (int i = 0; i < 7; i++) begin
            enable   = 1'b0;
            ref_run  = 1'b0;
            ref_half = VECS[i].half;
            lo_limit = VECS[i].lo;
            hi_limit = VECS[i].hi;
            wait_cycles(2);
            pulse_clear();
            enable  = 1'b1;
            ref_run = 1'b1;
            wait_cycles(10 * VECS[i].half + 20);
            check($sformatf("R2 vec%0d slow", i), err_slow, VECS[i].slow);
            check($sformatf("R3 vec%0d fast", i), err_fast, VECS[i].fast);
            check($sformatf("R7 vec%0d noref", i), err_noref, 1'b0);
        end

        // R6: sticky fast flag with limits opened again
        enable = 1'b0; ref_run = 1'b0; ref_half = 10;
        lo_limit = 8'd10; hi_limit = 8'd19;
        wait_cycles(2); pulse_clear();
        enable = 1'b1; ref_run = 1'b1;
        wait_cycles(120);
        hi_limit = 8'd30;
        wait_cycles(120);
        check("R6 sticky fast", err_fast, 1'b1);
        // R8: clear
        pulse_clear();
        check("R8 clear fast", err_fast, 1'b0);
        check("R8 clear slow", err_slow, 1'b0);

        // R4: first window after enable is discarded
        enable = 1'b0; lo_limit = 8'd20; hi_limit = 8'd20;
        wait_cycles(40); pulse_clear();
        wait_cycles(7);
        enable = 1'b1;
        wait_cycles(30);
        check("R4 discard slow", err_slow, 1'b0);
        check("R4 discard fast", err_fast, 1'b0);

        // R7: gap below and above timeout
        ref_run = 1'b0;
        wait_cycles(400);
        check("R7 short gap", err_noref, 1'b0);
        wait_cycles(800);
        check("R7 dead reference", err_noref, 1'b1);
        check("R7 no compare while dead", err_slow, 1'b0);

        // R9: bypass suspends everything
        pulse_clear();
        bypass = 1'b1; lo_limit = 8'd5; hi_limit = 8'd5;
        ref_run = 1'b1;
        wait_cycles(200);
        ref_run = 1'b0;
        wait_cycles(1500);
        check("R9 bypass fast", err_fast, 1'b0);
        check("R9 bypass noref", err_noref, 1'b0);
        bypass = 1'b0;

        // R10: reset clears set flags
        wait_cycles(1200);
        rst_n = 1'b0;
        wait_cycles(2);
        check("R10 reset noref", err_noref, 1'b0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule